// File: doc/BRIEF.md
# Multiprocessor Level Interrupt Controller

This block collects level-sensitive interrupt sources and hands them to a small group of CPUs through one memory-mapped register port. A shared global space holds a per-source enable and a per-source routing bitmap. A per-CPU window holds a per-CPU mask and an acknowledge register. Each access carries the number of the CPU that issues it, and that number picks which per-CPU window is seen. Enable and mask registers are written with a source number, not a bitmask. One write changes the bit of exactly that source.

Each CPU has one interrupt output. The output is high while any source is eligible for that CPU. Reading the acknowledge register returns the lowest eligible source number, or 1023 when none is eligible. The read has no side effect. Source 0 carries a per-CPU doorbell summary input. Source `TIMER_SRC` (5 by default) carries a per-CPU timer input. Both of these are gated only by the CPU's own mask. Write effects are registered. Read data and interrupt outputs are combinational from the current state and inputs.

Top module: `irqhub`

## Requirements
- R1: A read of global address 0x000 returns `NUM_SRC` in bits [11:2] and zero in every other bit.
- R2: Writing source number n (n < `NUM_SRC`) to 0x030 sets the enable of n, and writing it to 0x034 clears that enable. Numbers of `NUM_SRC` or more change no enable.
- R3: Writing source number n to per-CPU address 0x848 masks n, and writing it to 0x84C unmasks n. The change applies only to the CPU on `reqCpu`.
- R4: The word at 0x100 + 4·n holds the routing bitmap of source n in bits [NUM_CPU-1:0], with bit c meaning CPU c. The word reads back as written.
- R5: An ordinary source n (not 0, not `TIMER_SRC`) is eligible for CPU c only while `srcLvl[n]` is high, n is enabled, n is unmasked for c, and routing bit c of n is set. It stops being eligible as soon as its level falls.
- R6: A read of 0x844 returns, in bits [9:0], the lowest-numbered source eligible for the requesting CPU, or 1023 if none is eligible. Repeated reads return the same value.
- R7: Source 0 is eligible for CPU c while `dbPend[c]` is high and source 0 is unmasked for c.
- R8: Source `TIMER_SRC` is eligible for CPU c while `timerLvl[c]` is high and that source is unmasked for c. Its enable and routing have no effect.
- R9: `cpuIrq[c]` is high exactly while at least one source is eligible for CPU c.
- R10: After reset all enables are clear, all masks are set and all routing bitmaps are zero. The acknowledge read then gives 1023 and every `cpuIrq` bit is low.
- R11: A source routed to and unmasked for two CPUs is reported to both. One CPU's acknowledge does not remove it from the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the register port |
| reqCpu | input | CPU_W | Number of the CPU issuing the access |
| addr | input | ADDR_W | Byte address; bit 11 set selects the per-CPU window |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr`, combinational |
| srcLvl | input | NUM_SRC | Level inputs of the ordinary sources |
| timerLvl | input | NUM_CPU | Per-CPU timer level, reported as source `TIMER_SRC` |
| dbPend | input | NUM_CPU | Per-CPU doorbell summary, reported as source 0 |
| cpuIrq | output | NUM_CPU | Interrupt output per CPU |

## Verification
A wrong enable, mask or routing bit shows up on the next clock edge after the write that caused it. It appears either as a wrong number from the acknowledge read or as a wrong `cpuIrq` level. Both are combinational from state, so the bench checks them one sample after each edge. The riskiest decode paths get their own checks. These are out-of-range source numbers that could alias a valid one, a mask write that touches the wrong CPU, and the two special sources that bypass enable and routing. Each of them would change the reported source number at once.

// File: rtl/irqhub_pkg.sv
package irqhub_pkg;

  // Single-cycle write strobes from decode to the register file
  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic setMask;
    logic clrMask;
    logic routeWr;
  } regStb_t;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_CTRL,
    RD_ROUTE,
    RD_ACK
  } rdSel_t;

  localparam int SRC_ID_W = 10;
  localparam logic [SRC_ID_W-1:0] SPURIOUS_ID = 10'd1023;

endpackage

// File: rtl/irqhub_ctrl.sv
module irqhub_ctrl
  import irqhub_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int SRC_W   = 5
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output regStb_t           stb,
  output logic [SRC_W-1:0]  wrIdx,
  output rdSel_t            rdSel,
  output logic [SRC_W-1:0]  rdIdx
);

  localparam logic [ADDR_W-1:0] OFS_CTRL   = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] OFS_EN_SET = ADDR_W'('h030);
  localparam logic [ADDR_W-1:0] OFS_EN_CLR = ADDR_W'('h034);
  localparam logic [ADDR_W-1:0] OFS_ROUTE  = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] ROUTE_END  = ADDR_W'('h100 + 4 * NUM_SRC);
  localparam logic [ADDR_W-1:0] OFS_ACK    = ADDR_W'('h844);
  localparam logic [ADDR_W-1:0] OFS_MASK   = ADDR_W'('h848);
  localparam logic [ADDR_W-1:0] OFS_UNMASK = ADDR_W'('h84C);

  logic [ADDR_W-1:0] routeOfs;
  logic              inRoute;
  logic              numOk;
  logic [SRC_W-1:0]  routeIdx;

  assign routeOfs = addr - OFS_ROUTE;
  assign routeIdx = routeOfs[SRC_W+1:2];
  assign inRoute  = (addr >= OFS_ROUTE) && (addr < ROUTE_END) && (addr[1:0] == 2'b00);
  // Full-width compare so that large numbers never alias a valid source
  assign numOk    = (wrData[SRC_ID_W-1:0] < SRC_ID_W'(NUM_SRC)) &&
                    (wrData[DATA_W-1:SRC_ID_W] == '0);

  assign wrIdx = inRoute ? routeIdx : wrData[SRC_W-1:0];
  assign rdIdx = routeIdx;

  always_comb begin
    stb = '0;
    if (wrEn) begin
      if (inRoute)                       stb.routeWr = 1'b1;
      else if (addr == OFS_EN_SET && numOk) stb.setEn   = 1'b1;
      else if (addr == OFS_EN_CLR && numOk) stb.clrEn   = 1'b1;
      else if (addr == OFS_MASK && numOk)   stb.setMask = 1'b1;
      else if (addr == OFS_UNMASK && numOk) stb.clrMask = 1'b1;
    end
  end

  always_comb begin
    if (addr == OFS_CTRL)     rdSel = RD_CTRL;
    else if (inRoute)         rdSel = RD_ROUTE;
    else if (addr == OFS_ACK) rdSel = RD_ACK;
    else                      rdSel = RD_NONE;
  end

endmodule

// File: rtl/irqhub_datapath.sv
module irqhub_datapath
  import irqhub_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_CPU   = 2,
  parameter int TIMER_SRC = 5,
  parameter int SRC_W     = 5,
  parameter int CPU_W     = 1,
  parameter int DATA_W    = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStb_t            stb,
  input  logic [SRC_W-1:0]   wrIdx,
  input  logic [CPU_W-1:0]   cpuSel,
  input  logic [DATA_W-1:0]  wrData,
  input  rdSel_t             rdSel,
  input  logic [SRC_W-1:0]   rdIdx,
  input  logic [NUM_SRC-1:0] srcLvl,
  input  logic [NUM_CPU-1:0] timerLvl,
  input  logic [NUM_CPU-1:0] dbPend,
  output logic [NUM_CPU-1:0] cpuIrq,
  output logic [DATA_W-1:0]  rdData
);

  logic [NUM_SRC-1:0]               enableQ;
  logic [NUM_CPU-1:0][NUM_SRC-1:0]  maskQ;
  logic [NUM_SRC-1:0][NUM_CPU-1:0]  routeQ;
  logic [NUM_CPU-1:0][NUM_SRC-1:0]  elig;
  logic [NUM_CPU-1:0][SRC_ID_W-1:0] ackId;
  logic                             cpuOk;

  assign cpuOk = (32'(cpuSel) < NUM_CPU);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      maskQ   <= '1;
      routeQ  <= '0;
    end else begin
      if (stb.setEn)            enableQ[wrIdx]        <= 1'b1;
      if (stb.clrEn)            enableQ[wrIdx]        <= 1'b0;
      if (stb.setMask && cpuOk) maskQ[cpuSel][wrIdx]  <= 1'b1;
      if (stb.clrMask && cpuOk) maskQ[cpuSel][wrIdx]  <= 1'b0;
      if (stb.routeWr)          routeQ[wrIdx]         <= wrData[NUM_CPU-1:0];
    end
  end

  // Eligibility: doorbell and timer slots bypass enable and routing
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      if (n == 0) begin : g_db
        assign elig[c][n] = dbPend[c] & ~maskQ[c][n];
      end else if (n == TIMER_SRC) begin : g_tmr
        assign elig[c][n] = timerLvl[c] & ~maskQ[c][n];
      end else begin : g_std
        assign elig[c][n] = srcLvl[n] & enableQ[n] & ~maskQ[c][n] & routeQ[n][c];
      end
    end

    assign cpuIrq[c] = |elig[c];

    always_comb begin
      ackId[c] = SPURIOUS_ID;
      for (int n = NUM_SRC - 1; n >= 0; n--) begin
        if (elig[c][n]) ackId[c] = SRC_ID_W'(n);
      end
    end

    // R9: an asserted output needs some live input behind it
    p_irq_has_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
      cpuIrq[c] |-> ((|srcLvl) || dbPend[c] || timerLvl[c]));
  end

  always_comb begin
    unique case (rdSel)
      RD_CTRL:  rdData = DATA_W'(NUM_SRC) << 2;
      RD_ROUTE: rdData = DATA_W'(routeQ[rdIdx]);
      RD_ACK:   rdData = cpuOk ? DATA_W'(ackId[cpuSel]) : DATA_W'(SPURIOUS_ID);
      default:  rdData = '0;
    endcase
  end

  logic unusedBits;
  assign unusedBits = srcLvl[0] ^ srcLvl[TIMER_SRC] ^ enableQ[0] ^ enableQ[TIMER_SRC]
                      ^ (^wrData[DATA_W-1:NUM_CPU]);

  p_set_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.setEn |=> enableQ[$past(wrIdx)]);

  p_clear_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrEn |=> !enableQ[$past(wrIdx)]);

  p_mask_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setMask && cpuOk) |=> maskQ[$past(cpuSel)][$past(wrIdx)]);

  p_mask_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrMask && cpuOk) |=> !maskQ[$past(cpuSel)][$past(wrIdx)]);

  p_route_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.routeWr |=> (routeQ[$past(wrIdx)] == $past(wrData[NUM_CPU-1:0])));

endmodule

// File: rtl/irqhub.sv
module irqhub
  import irqhub_pkg::*;
#(
  parameter int NUM_CPU   = 2,
  parameter int NUM_SRC   = 32,
  parameter int TIMER_SRC = 5,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [CPU_W-1:0]   reqCpu,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] srcLvl,
  input  logic [NUM_CPU-1:0] timerLvl,
  input  logic [NUM_CPU-1:0] dbPend,
  output logic [NUM_CPU-1:0] cpuIrq
);

  regStb_t          stb;
  rdSel_t           rdSel;
  logic [SRC_W-1:0] wrIdx;
  logic [SRC_W-1:0] rdIdx;

  irqhub_ctrl #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W)
  ) u_ctrl (
    .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .stb(stb), .wrIdx(wrIdx), .rdSel(rdSel), .rdIdx(rdIdx)
  );

  irqhub_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .TIMER_SRC(TIMER_SRC),
    .SRC_W(SRC_W), .CPU_W(CPU_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrIdx(wrIdx), .cpuSel(reqCpu),
    .wrData(wrData), .rdSel(rdSel), .rdIdx(rdIdx), .srcLvl(srcLvl),
    .timerLvl(timerLvl), .dbPend(dbPend), .cpuIrq(cpuIrq), .rdData(rdData)
  );

endmodule

// File: tb/irqhub_tb.sv
`timescale 1ns/1ps
module irqhub_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [0:0]  reqCpu = '0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] srcLvl = '0;
  logic [1:0]  timerLvl = '0;
  logic [1:0]  dbPend = '0;
  logic [1:0]  cpuIrq;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irqhub u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .reqCpu(reqCpu), .addr(addr),
    .wrData(wrData), .rdData(rdData), .srcLvl(srcLvl), .timerLvl(timerLvl),
    .dbPend(dbPend), .cpuIrq(cpuIrq)
  );

  typedef struct packed {
    logic [31:0] lvl;
    logic        we;
    logic        cpu;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 27;
  localparam vec_t VECS [NVEC] = '{
    '{32'h00, 1'b0, 1'b0, 12'h000, 32'd0,  32'h80,  4'd1},  // R1 control word
    '{32'h00, 1'b0, 1'b0, 12'h844, 32'd0,  32'd1023, 4'd10}, // R10 nothing pending
    '{32'h80, 1'b1, 1'b0, 12'h030, 32'd7,  32'd0,   4'd2},
    '{32'h80, 1'b1, 1'b0, 12'h11C, 32'd1,  32'd0,   4'd4},
    '{32'h80, 1'b0, 1'b0, 12'h844, 32'd0,  32'd1023, 4'd3},  // R3 still masked
    '{32'h80, 1'b1, 1'b0, 12'h84C, 32'd7,  32'd0,   4'd3},
    '{32'h80, 1'b0, 1'b0, 12'h844, 32'd0,  32'd7,   4'd5},   // R5 eligible
    '{32'h80, 1'b0, 1'b0, 12'h844, 32'd0,  32'd7,   4'd6},   // R6 read has no side effect
    '{32'h80, 1'b0, 1'b1, 12'h844, 32'd0,  32'd1023, 4'd3},  // R3 other CPU
    '{32'h80, 1'b0, 1'b0, 12'h11C, 32'd0,  32'd1,   4'd4},   // R4 route readback
    '{32'h88, 1'b1, 1'b0, 12'h030, 32'd3,  32'd0,   4'd2},
    '{32'h88, 1'b1, 1'b0, 12'h10C, 32'd3,  32'd0,   4'd4},
    '{32'h88, 1'b1, 1'b0, 12'h84C, 32'd3,  32'd0,   4'd3},
    '{32'h88, 1'b0, 1'b0, 12'h844, 32'd0,  32'd3,   4'd6},   // R6 lowest wins
    '{32'h88, 1'b1, 1'b0, 12'h034, 32'd3,  32'd0,   4'd2},
    '{32'h88, 1'b0, 1'b0, 12'h844, 32'd0,  32'd7,   4'd2},   // R2 clear enable
    '{32'h88, 1'b1, 1'b0, 12'h034, 32'd39, 32'd0,   4'd2},
    '{32'h88, 1'b0, 1'b0, 12'h844, 32'd0,  32'd7,   4'd2},   // R2 out-of-range ignored
    '{32'h08, 1'b0, 1'b0, 12'h844, 32'd0,  32'd1023, 4'd5},  // R5 level dropped
    '{32'h08, 1'b1, 1'b1, 12'h84C, 32'd3,  32'd0,   4'd3},
    '{32'h08, 1'b1, 1'b0, 12'h030, 32'd3,  32'd0,   4'd2},
    '{32'h08, 1'b0, 1'b1, 12'h844, 32'd0,  32'd3,   4'd11},  // R11 CPU1 sees it
    '{32'h08, 1'b0, 1'b0, 12'h844, 32'd0,  32'd3,   4'd11},  // R11 CPU0 sees it too
    '{32'h08, 1'b1, 1'b0, 12'h848, 32'd3,  32'd0,   4'd3},
    '{32'h08, 1'b0, 1'b0, 12'h844, 32'd0,  32'd1023, 4'd3},  // R3 CPU0 masked
    '{32'h08, 1'b0, 1'b1, 12'h844, 32'd0,  32'd3,   4'd3},   // R3 CPU1 untouched
    '{32'h08, 1'b0, 1'b0, 12'h10C, 32'd0,  32'd3,   4'd4}    // R4 both bits
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic cpu, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reqCpu = cpu; addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readChk(input logic cpu, input logic [11:0] a, input logic [31:0] exp,
                         input string req);
    reqCpu = cpu; addr = a; wrEn = 1'b0;
    #1;
    check(rdData == exp, req, rdData, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(cpuIrq == 2'b00, "R10", 32'(cpuIrq), 0);

    for (int i = 0; i < NVEC; i++) begin
      srcLvl = VECS[i].lvl;
      if (VECS[i].we) begin
        doWrite(VECS[i].cpu, VECS[i].addr, VECS[i].data);
      end else begin
        readChk(VECS[i].cpu, VECS[i].addr, VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i));
      end
    end

    // R9: CPU1 has source 3, CPU0 nothing
    #1;
    check(cpuIrq == 2'b10, "R9", 32'(cpuIrq), 2);

    // R8: timer bypasses enable and routing, gated by own mask
    timerLvl = 2'b01;
    #1;
    check(cpuIrq == 2'b10, "R8 masked timer", 32'(cpuIrq), 2);
    doWrite(1'b0, 12'h84C, 32'd5);
    readChk(1'b0, 12'h844, 32'd5, "R8 timer ack");
    readChk(1'b1, 12'h844, 32'd3, "R8 other cpu");
    check(cpuIrq == 2'b11, "R9 both", 32'(cpuIrq), 3);

    // R7: doorbell summary as source 0
    dbPend = 2'b10;
    readChk(1'b1, 12'h844, 32'd3, "R7 masked doorbell");
    doWrite(1'b1, 12'h84C, 32'd0);
    readChk(1'b1, 12'h844, 32'd0, "R7 doorbell ack");
    readChk(1'b0, 12'h844, 32'd5, "R7 cpu0 unaffected");

    // R10: reset with live inputs
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    readChk(1'b0, 12'h844, 32'd1023, "R10 cpu0 ack");
    readChk(1'b1, 12'h844, 32'd1023, "R10 cpu1 ack");
    readChk(1'b0, 12'h10C, 32'd0, "R10 route");
    check(cpuIrq == 2'b00, "R10 irq", 32'(cpuIrq), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failCnt++;
      testCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule